// File: doc/BRIEF.md
# Cipher Engine Control Front End

This block sits in front of a block-cipher datapath. It holds the engine's control word and two 8-word FIFOs of 32-bit words, one carrying words toward the cipher core and one carrying results back. It also drives a pair of DMA request lines toward a DMA controller. Software or the DMA controller reaches everything over a simple register bus. A write to the data-in address pushes a word. A read of the data-out address pops a result.

Each DMA request line is an output with a matching clear input. A request is raised when its FIFO can take or deliver a burst of up to four words. It then stays high until the controller answers with the clear. The cipher datapath is represented by a stub. When the engine is enabled, the stub moves one word per cycle from the input FIFO to the output FIFO, and it inverts every bit when the direction bit is set. A completion pulse from the core ends key preparation by clearing the enable bit.

Register map (word addresses): 0 control, 1 DMA enables, 2 data in (write), 3 data out (read), 4 status.

Top module: `cipher_front`

## Requirements
- R1: After reset the control word reads 0x00000000, the status word reads 0, and both DMA requests are low.
- R2: Control field layout: enable is bit 15, flush is bit 14, key size is bits 9:8, data type is bits 7:6, algorithm mode is bits 5:3 and direction is bit 2. Bits 31:16, 14, 13:10 and 1:0 always read 0.
- R3: `key_words` is 4, 6 or 8 for key size 00, 01 or 10 when mode bit 2 is 1 (the AES modes). It is 0 when mode bit 2 is 0. A write with key size 11 leaves the stored key size unchanged.
- R4: Writing the control word with bit 14 set while the engine is disabled empties both FIFOs. The counts then read 0.
- R5: While the engine is enabled, the flush bit of a control write has no effect on either FIFO.
- R6: A data-in write to a full input FIFO is dropped, and a data-out read of an empty output FIFO pops nothing. Either event sets status bit 0, which stays set until 1 is written to bit 0 of the status address. Status bits 15:8 hold the input count and bits 23:16 hold the output count.
- R7: Both requests are low while enable is 0. The input request is low while DMA-enable bit 0 is 0, and the output request is low while DMA-enable bit 1 is 0.
- R8: A raised request stays high until its clear input is high. It cannot rise again while that clear input remains high.
- R9: The output request rises when the output FIFO holds at least 4 words, or holds any word while the input FIFO is empty.
- R10: The input request rises only when the input FIFO has at least 4 free entries.
- R11: A core completion pulse while mode is 111 clears the enable bit. In other modes the pulse leaves enable unchanged.
- R12: A control write setting enable in the same cycle as a mode-111 completion pulse leaves enable at 0.
- R13: Words leave the output FIFO in the order they were written, each inverted when direction is 1 and unchanged when direction is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops at address 3) |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| dma_in_req | output | 1 | Input-side DMA request |
| dma_in_clr | input | 1 | Input-side request clear |
| dma_out_req | output | 1 | Output-side DMA request |
| dma_out_clr | input | 1 | Output-side request clear |
| core_done | input | 1 | Completion pulse from the cipher core |
| key_words | output | 4 | Key length in 32-bit words for the core |
| ctl_mode | output | 3 | Algorithm mode to the core |
| ctl_dir | output | 1 | Direction to the core |
| ctl_dtype | output | 2 | Data type to the core |

## Verification
The hardest state to reach from the ports is an input FIFO that holds data while the engine is enabled. The stub drains the input FIFO within a cycle, so the input request can normally never be seen falling short of room. The stimulus first fills the output FIFO to eight words so the stub stalls. It then writes five more words and checks that the input request stays low. After one word is read out, the stub moves one word and frees a fourth entry, and the request must come up. The same stalled state, with the output FIFO full and the input FIFO not empty, shows the output request firing on the four-word threshold rather than on the idle rule.

// File: rtl/cipher_front_pkg.sv
package cipher_front_pkg;
  localparam int DW = 32;

  localparam int EN_BIT = 15;
  localparam int FL_BIT = 14;

  localparam logic [2:0] MODE_KEYPREP = 3'b111;
  localparam logic [1:0] KS_RSVD      = 2'b11;

  // Key length in words; non-AES modes (mode bit 2 clear) have none.
  function automatic logic [3:0] key_words_f(input logic [2:0] mode, input logic [1:0] ks);
    if (!mode[2]) return 4'd0;
    case (ks)
      2'b00:   return 4'd4;
      2'b01:   return 4'd6;
      2'b10:   return 4'd8;
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic [DW-1:0] ctl_pack(input logic en, input logic [1:0] ks,
                                             input logic [1:0] dt, input logic [2:0] mode,
                                             input logic dir);
    return {16'h0, en, 1'b0, 4'h0, ks, dt, mode, dir, 2'b00};
  endfunction
endpackage

// File: rtl/cfe_fifo.sv
module cfe_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  logic [DW-1:0]                din,
  input  logic                         pop,
  output logic [DW-1:0]                dout,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic do_push, do_pop;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = empty ? '0 : mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/cfe_dma_req.sv
module cfe_dma_req (
  input  logic clk,
  input  logic rst_n,
  input  logic gate,
  input  logic cond,
  input  logic clr,
  output logic req
);
  logic req_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !gate) req_q <= 1'b0;
    else if (req_q)      req_q <= !clr;
    else                 req_q <= cond && !clr;
  end

  assign req = req_q && gate;
endmodule

// File: rtl/cfe_core_stub.sv
module cfe_core_stub #(
  parameter int DW = 32
) (
  input  logic          en,
  input  logic          dir,
  input  logic          in_empty,
  input  logic [DW-1:0] in_data,
  input  logic          out_full,
  output logic          in_pop,
  output logic          out_push,
  output logic [DW-1:0] out_data
);
  assign in_pop   = en && !in_empty && !out_full;
  assign out_push = in_pop;
  assign out_data = in_data ^ {DW{dir}};
endmodule

// File: rtl/cipher_front.sv
module cipher_front #(
  parameter int DEPTH = 8,
  parameter int BURST = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        dma_in_req,
  input  logic        dma_in_clr,
  output logic        dma_out_req,
  input  logic        dma_out_clr,
  input  logic        core_done,
  output logic [3:0]  key_words,
  output logic [2:0]  ctl_mode,
  output logic        ctl_dir,
  output logic [1:0]  ctl_dtype
);
  import cipher_front_pkg::*;
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [2:0] A_CTL = 3'd0, A_DMA = 3'd1, A_DIN = 3'd2, A_DOUT = 3'd3, A_STAT = 3'd4;

  logic       en_q, dir_q, din_en_q, dout_en_q, err_q;
  logic [1:0] ks_q, dt_q;
  logic [2:0] mode_q;

  // named internal events
  logic wr_ctl, auto_clr, flush_evt, err_set, err_clr;
  logic in_push, in_ovf, out_pop, out_unf;
  logic in_gate, out_gate, in_cond, out_cond;

  logic [DW-1:0] in_dout, out_dout, stub_data;
  logic [CW-1:0] in_count, out_count;
  logic in_full, in_empty, out_full, out_empty, stub_pop, stub_push;

  assign wr_ctl    = bus_wr && bus_addr == A_CTL;
  assign auto_clr  = core_done && mode_q == MODE_KEYPREP;
  assign flush_evt = wr_ctl && bus_wdata[FL_BIT] && !en_q;
  assign in_push   = bus_wr && bus_addr == A_DIN;
  assign in_ovf    = in_push && in_full;
  assign out_pop   = bus_rd && bus_addr == A_DOUT;
  assign out_unf   = out_pop && out_empty;
  assign err_set   = in_ovf || out_unf;
  assign err_clr   = bus_wr && bus_addr == A_STAT && bus_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; dir_q <= 1'b0; ks_q <= '0; dt_q <= '0; mode_q <= '0;
      din_en_q <= 1'b0; dout_en_q <= 1'b0; err_q <= 1'b0;
    end else begin
      if (auto_clr)    en_q <= 1'b0;
      else if (wr_ctl) en_q <= bus_wdata[EN_BIT];
      if (wr_ctl) begin
        if (bus_wdata[9:8] != KS_RSVD) ks_q <= bus_wdata[9:8];
        dt_q   <= bus_wdata[7:6];
        mode_q <= bus_wdata[5:3];
        dir_q  <= bus_wdata[2];
      end
      if (bus_wr && bus_addr == A_DMA) begin
        din_en_q  <= bus_wdata[0];
        dout_en_q <= bus_wdata[1];
      end
      if (err_set)      err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
    end
  end

  cfe_fifo #(.DW(DW), .DEPTH(DEPTH)) in_fifo_i (
    .clk(clk), .rst_n(rst_n), .flush(flush_evt), .push(in_push), .din(bus_wdata),
    .pop(stub_pop), .dout(in_dout), .count(in_count), .full(in_full), .empty(in_empty));

  cfe_fifo #(.DW(DW), .DEPTH(DEPTH)) out_fifo_i (
    .clk(clk), .rst_n(rst_n), .flush(flush_evt), .push(stub_push), .din(stub_data),
    .pop(out_pop), .dout(out_dout), .count(out_count), .full(out_full), .empty(out_empty));

  cfe_core_stub #(.DW(DW)) stub_i (
    .en(en_q), .dir(dir_q), .in_empty(in_empty), .in_data(in_dout), .out_full(out_full),
    .in_pop(stub_pop), .out_push(stub_push), .out_data(stub_data));

  assign in_gate  = en_q && din_en_q;
  assign out_gate = en_q && dout_en_q;
  assign in_cond  = (CW'(DEPTH) - in_count) >= CW'(BURST);
  assign out_cond = (out_count >= CW'(BURST)) || (!out_empty && in_empty);

  cfe_dma_req in_req_i (.clk(clk), .rst_n(rst_n), .gate(in_gate), .cond(in_cond),
                        .clr(dma_in_clr), .req(dma_in_req));
  cfe_dma_req out_req_i (.clk(clk), .rst_n(rst_n), .gate(out_gate), .cond(out_cond),
                         .clr(dma_out_clr), .req(dma_out_req));

  always_comb begin
    case (bus_addr)
      A_CTL:   bus_rdata = ctl_pack(en_q, ks_q, dt_q, mode_q, dir_q);
      A_DMA:   bus_rdata = {30'h0, dout_en_q, din_en_q};
      A_DOUT:  bus_rdata = out_dout;
      A_STAT:  bus_rdata = {8'h0, 8'(out_count), 8'(in_count), 7'h0, err_q};
      default: bus_rdata = '0;
    endcase
  end

  assign key_words = key_words_f(mode_q, ks_q);
  assign ctl_mode  = mode_q;
  assign ctl_dir   = dir_q;
  assign ctl_dtype = dt_q;
endmodule

// File: rtl/cipher_front_chk.sv
module cipher_front_chk #(
  parameter int DEPTH = 8,
  parameter int BURST = 4,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dma_in_req,
  input logic          dma_in_clr,
  input logic          dma_out_req,
  input logic          dma_out_clr,
  input logic          in_gate,
  input logic          out_gate,
  input logic          en_q,
  input logic          auto_clr,
  input logic          flush_evt,
  input logic [CW-1:0] in_count,
  input logic [CW-1:0] out_count,
  input logic          err_q,
  input logic          err_clr
);
  assert_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (!dma_in_req && !dma_out_req));

  assert_in_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_in_req && !dma_in_clr) |=> (dma_in_req || !in_gate));
  assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_out_req && !dma_out_clr) |=> (dma_out_req || !out_gate));
  assert_in_rearm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_in_clr && !dma_in_req) |=> !dma_in_req);
  assert_out_rearm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_out_clr && !dma_out_req) |=> !dma_out_req);

  assert_in_room_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_in_req) |-> ($past(in_count) <= CW'(DEPTH - BURST)));

  assert_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flush_evt |=> (in_count == '0 && out_count == '0));

  assert_autoclr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    auto_clr |=> !en_q);

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !err_clr) |=> err_q);
endmodule

bind cipher_front cipher_front_chk #(.DEPTH(DEPTH), .BURST(BURST), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .dma_in_req(dma_in_req), .dma_in_clr(dma_in_clr),
  .dma_out_req(dma_out_req), .dma_out_clr(dma_out_clr), .in_gate(in_gate),
  .out_gate(out_gate), .en_q(en_q), .auto_clr(auto_clr), .flush_evt(flush_evt),
  .in_count(in_count), .out_count(out_count), .err_q(err_q), .err_clr(err_clr));

// File: tb/cipher_front_tb_top.sv
module cipher_front_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] EN = 32'h8000, FL = 32'h4000, DIR = 32'h4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 0, bus_rd = 0, dma_in_clr = 0, dma_out_clr = 0, core_done = 0;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic dma_in_req, dma_out_req, ctl_dir;
  logic [3:0] key_words;
  logic [2:0] ctl_mode;
  logic [1:0] ctl_dtype;

  int n_tests = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  logic cur_dir = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cipher_front dut_i (.*);

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic bw(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic br(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: push a word and record the expected result
  task automatic drive(input logic [31:0] w);
    exp_q.push_back(w ^ {32{cur_dir}});
    bw(3'd2, w);
  endtask

  // monitor: pop a result and compare with the scoreboard
  task automatic mon_pop();
    logic [31:0] d, e;
    br(3'd3, d);
    e = exp_q.pop_front();
    chk("R13 data order/transform", d, e);
  endtask

  task automatic chk_rd(input string r, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] d;
    br(a, d);
    chk(r, d, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle(3); rst_n = 1'b1;
    // R1 reset state
    chk_rd("R1 ctl reset", 3'd0, 32'h0);
    chk_rd("R1 status reset", 3'd4, 32'h0);
    chk("R1 reqs low", {30'h0, dma_in_req, dma_out_req}, 32'h0);

    // R2 layout, reserved and flush read 0; R3 key size 11 kept at 00
    bw(3'd0, 32'hFFFF_FFFF);
    chk_rd("R2 ctl readback", 3'd0, 32'h0000_80FC);
    bw(3'd0, 32'h0);

    // R3 key length
    bw(3'd0, 32'h0000_0120); idle(1); chk("R3 key 192", 32'(key_words), 32'd6);
    bw(3'd0, 32'h0000_0220); idle(1); chk("R3 key 256", 32'(key_words), 32'd8);
    bw(3'd0, 32'h0000_0320); idle(1); chk("R3 rsvd size kept", 32'(key_words), 32'd8);
    bw(3'd0, 32'h0000_0208); idle(1); chk("R3 non-AES", 32'(key_words), 32'd0);
    bw(3'd0, 32'h0);

    // R4 flush while disabled
    bw(3'd2, 32'h11); bw(3'd2, 32'h22); bw(3'd2, 32'h33);
    chk_rd("R6 in count field", 3'd4, 32'h0000_0300);
    bw(3'd0, FL);
    chk_rd("R4 flush empties", 3'd4, 32'h0);

    // R5, R13 with inversion
    cur_dir = 1'b1;
    bw(3'd0, EN | DIR);
    drive(32'hA5A5_0001); drive(32'h1234_5678); drive(32'hFFFF_0000);
    idle(3);
    chk_rd("R13 out count", 3'd4, 32'h0003_0000);
    bw(3'd0, EN | DIR | FL); idle(2);
    chk_rd("R5 flush ignored while enabled", 3'd4, 32'h0003_0000);
    repeat (3) mon_pop();
    cur_dir = 1'b0;
    bw(3'd0, EN);
    drive(32'hDEAD_BEEF); drive(32'h0000_0042); idle(3);
    repeat (2) mon_pop();

    // R6 overflow, underflow, sticky error
    bw(3'd0, 32'h0);
    for (int i = 0; i < 9; i++) bw(3'd2, 32'(i));
    chk_rd("R6 overflow dropped, err set", 3'd4, 32'h0000_0801);
    idle(2);
    chk_rd("R6 err sticky", 3'd4, 32'h0000_0801);
    bw(3'd4, 32'h1);
    chk_rd("R6 err cleared", 3'd4, 32'h0000_0800);
    bw(3'd0, FL);
    chk_rd("R6 underflow read value", 3'd3, 32'h0);
    chk_rd("R6 underflow err", 3'd4, 32'h0000_0001);
    bw(3'd4, 32'h1);

    // R7, R8 input request handshake
    bw(3'd1, 32'h1); idle(3);
    chk("R7 in req low while disabled", 32'(dma_in_req), 32'd0);
    bw(3'd0, EN); idle(3);
    chk("R10 in req with room", 32'(dma_in_req), 32'd1);
    idle(5);
    chk("R8 req held", 32'(dma_in_req), 32'd1);
    @(negedge clk); dma_in_clr = 1;
    idle(3);
    chk("R8 req dropped, no rearm under clr", 32'(dma_in_req), 32'd0);
    dma_in_clr = 0; idle(2);
    chk("R8 rearm after clr low", 32'(dma_in_req), 32'd1);
    bw(3'd1, 32'h0);
    chk("R7 in req low with dma off", 32'(dma_in_req), 32'd0);

    // R10, R9 with stalled stub
    for (int i = 0; i < 8; i++) drive(32'h100 + 32'(i));
    idle(3);
    for (int i = 0; i < 5; i++) drive(32'h200 + 32'(i));
    idle(2);
    chk_rd("R10 stalled counts", 3'd4, 32'h0008_0500);
    bw(3'd1, 32'h1); idle(3);
    chk("R10 no req with 3 free", 32'(dma_in_req), 32'd0);
    mon_pop(); idle(3);
    chk("R10 req with 4 free", 32'(dma_in_req), 32'd1);
    bw(3'd1, 32'h2); idle(3);
    chk("R9 out req at threshold", 32'(dma_out_req), 32'd1);
    repeat (12) mon_pop();
    @(negedge clk); dma_out_clr = 1; idle(2); dma_out_clr = 0; idle(2);
    chk("R9 no out req when empty", 32'(dma_out_req), 32'd0);
    drive(32'h0BAD_F00D); idle(4);
    chk("R9 out req on idle remainder", 32'(dma_out_req), 32'd1);
    mon_pop();
    bw(3'd1, 32'h0);

    // R11, R12 auto-clear
    bw(3'd0, EN | 32'h38);
    @(negedge clk); core_done = 1; @(negedge clk); core_done = 0;
    chk_rd("R11 keyprep clears enable", 3'd0, 32'h0000_0038);
    bw(3'd0, EN | 32'h20);
    @(negedge clk); core_done = 1; @(negedge clk); core_done = 0;
    chk_rd("R11 other mode keeps enable", 3'd0, 32'h0000_8020);
    bw(3'd0, EN | 32'h38);
    @(negedge clk); bus_wr = 1; bus_addr = 3'd0; bus_wdata = EN | 32'h38; core_done = 1;
    @(negedge clk); bus_wr = 0; core_done = 0;
    chk_rd("R12 hw clear wins", 3'd0, 32'h0000_0038);

    chk("R13 scoreboard drained", 32'(exp_q.size()), 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule